// File: doc/BRIEF.md
# Root-Port Legacy Interrupt Event Queue

This block collects legacy level-interrupt events for a PCIe root port and presents them to software through a small register window on a 32-bit read/write bus. Each event gives a lane number (0 to 3) and a level: asserted or released. The block stores each event as an encoded record in a circular queue. Software reads the oldest record through two head words, and a write to either head word removes that record. A pending-cause register has one bit for the queued legacy events and one for message-signalled interrupts. A mask register selects which causes drive the single level-sensitive interrupt output. A status register reports bridge enable, queue not-empty and a sticky overflow flag. A separate status word reports the state of the link.

The queue's occupancy is held in a three-state machine. Q_EMPTY has no records. Q_PARTIAL holds one record or more but has room for another. Q_FULL holds DEPTH-1 records. The transitions are these. Q_EMPTY goes to Q_PARTIAL, or straight to Q_FULL when only one slot is usable, when an event is accepted. Q_PARTIAL goes to Q_EMPTY when its last record is removed, goes to Q_FULL when the last free slot is taken, and stays put otherwise. Q_FULL goes back to Q_PARTIAL, or to Q_EMPTY when only one slot is usable, on a removal that has no event in the same cycle. Q_FULL holds on an event alone, which is dropped, and on an event together with a removal, which is accepted. The full check is made against the occupancy as it stands after that cycle's removal.

Register reads are combinational from the current address. Register writes take effect at the clock edge on which select and write-enable are high.

Top module: `rp_intq_ctrl`

## Requirements
- R1: After reset, these read as 0: the pending word (0x138), the mask (0x13C), the status word (0x148) and both head words (0x158, 0x15C). The irq output is low after reset.
- R2: A queued record reads in head word 0x158 with bit 31 = 1, bit 30 = 0, bit 29 = level and bits 28:27 = lane. All other bits are 0. Head word 0x15C always reads 0.
- R3: Records come out in arrival order. A write of any value to 0x158 or 0x15C removes the oldest record.
- R4: While the queue is empty, both head words read 0. A write to either head word while the queue is empty has no effect, so the next event to arrive becomes the head.
- R5: With DEPTH = 16, the queue holds 15 records. An event that arrives while 15 are held, with no removal in the same cycle, is dropped and sets bit 19 of 0x148. That bit stays set until a 1 is written to bit 19 of 0x148.
- R6: An event that arrives in the same cycle as a removal from a full queue is accepted. It does not set bit 19, and it is queued behind the 14 records that remain.
- R7: Bit 16 of 0x138 becomes 1 when an event is accepted. Writing 1 to bit 16 clears it only when the queue is empty after that cycle. While any record is held, bit 16 reads 1.
- R8: A one-cycle pulse on msi_pulse sets bit 17 of 0x138. Only a write of 1 to bit 17 of 0x138 clears it.
- R9: 0x13C reads back the last value written to it. irq is high exactly when the bitwise AND of 0x138 and 0x13C is non-zero.
- R10: Bit 0 of 0x148 reads back the last bit 0 written to 0x148. Bit 18 of 0x148 reads 1 exactly when the queue holds a record, and writes to bit 18 are ignored.
- R11: Bit 11 of 0x144 follows the link_up input. All other bits of 0x144 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One legacy interrupt event this cycle |
| evt_lane | input | 2 | Lane of the event |
| evt_level | input | 1 | 1 = assert, 0 = release |
| msi_pulse | input | 1 | One-cycle message-interrupt cause |
| link_up | input | 1 | Link state shown in 0x144 bit 11 |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions take for granted that evt_valid and msi_pulse are clean single-cycle strobes that change only between clock edges. They also take for granted that a write to a head word is a single-cycle access, so each cycle with select and write-enable high counts as exactly one removal. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It returns bus_sel to 0 after every write, and it makes the simultaneous event-and-removal case only by raising both strobes in the same half period.

// File: rtl/rp_intq_pkg.sv
package rp_intq_pkg;
    localparam logic [11:0] OFF_PEND  = 12'h138;
    localparam logic [11:0] OFF_MASK  = 12'h13C;
    localparam logic [11:0] OFF_LINK  = 12'h144;
    localparam logic [11:0] OFF_STAT  = 12'h148;
    localparam logic [11:0] OFF_HEAD1 = 12'h158;
    localparam logic [11:0] OFF_HEAD2 = 12'h15C;

    localparam int B_LEGACY = 16;
    localparam int B_MSG    = 17;
    localparam int B_LINK   = 11;
    localparam int B_BRIDGE = 0;
    localparam int B_NEMPTY = 18;
    localparam int B_OVF    = 19;
    localparam int B_LANE   = 27;
    localparam int B_LEVEL  = 29;
    localparam int B_VALID  = 31;

    typedef struct packed {
        logic       level;
        logic [1:0] lane;
    } intx_rec_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;
endpackage

// File: rtl/rp_intq_fifo.sv
module rp_intq_fifo
    import rp_intq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  intx_rec_t push_rec,
    input  logic      pop_req,
    output intx_rec_t head_rec,
    output logic      q_nonempty,
    output logic      nonempty_next,
    output logic      overflow_evt
);
    localparam int USABLE = DEPTH - 1;
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(USABLE + 1) + 1;
    localparam logic [CW-1:0] USABLE_C = CW'(USABLE);
    localparam logic [PW-1:0] LAST_P   = PW'(DEPTH - 1);

    q_state_e        state_q, state_d;
    logic [PW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]   count_q, count_d, count_after_pop;
    logic            pop_ok, push_ok;
    intx_rec_t       mem [DEPTH];

    always_comb begin
        pop_ok          = pop_req && (state_q != Q_EMPTY);
        count_after_pop = count_q - CW'(pop_ok);
        push_ok         = push_req && (count_after_pop != USABLE_C);
        count_d         = count_after_pop + CW'(push_ok);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (push_ok)
                    state_d = (count_d == USABLE_C) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (count_d == '0)
                    state_d = Q_EMPTY;
                else if (count_d == USABLE_C)
                    state_d = Q_FULL;
                else
                    state_d = Q_PARTIAL;
            end
            Q_FULL: begin
                if (pop_ok && !push_ok)
                    state_d = (count_d == '0) ? Q_EMPTY : Q_PARTIAL;
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= Q_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (push_ok)
                wr_ptr_q <= (wr_ptr_q == LAST_P) ? '0 : wr_ptr_q + 1'b1;
            if (pop_ok)
                rd_ptr_q <= (rd_ptr_q == LAST_P) ? '0 : rd_ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr_q] <= push_rec;
    end

    always_comb begin
        q_nonempty    = (state_q != Q_EMPTY);
        nonempty_next = (state_d != Q_EMPTY);
        overflow_evt  = push_req && !push_ok;
        head_rec      = mem[rd_ptr_q];
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= USABLE_C); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && push_req && !pop_req) |=> $stable(wr_ptr_q)); // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY && pop_req && !push_req) |=> (state_q == Q_EMPTY && $stable(rd_ptr_q))); // R4
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && push_req && pop_req) |=> (state_q == Q_FULL)); // R6
endmodule

// File: rtl/rp_intq_regs.sv
module rp_intq_regs
    import rp_intq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pend,
    input  logic          wr_mask,
    input  logic          wr_stat,
    input  logic [DW-1:0] wdata,
    input  logic          msi_pulse,
    input  logic          q_nonempty,
    input  logic          nonempty_next,
    input  logic          overflow_evt,
    output logic          legacy_q,
    output logic          msg_q,
    output logic [DW-1:0] mask_q,
    output logic          bridge_q,
    output logic          ovf_q,
    output logic          irq
);
    logic clr_legacy, clr_msg, clr_ovf;

    always_comb begin
        clr_legacy = wr_pend && wdata[B_LEGACY];
        clr_msg    = wr_pend && wdata[B_MSG];
        clr_ovf    = wr_stat && wdata[B_OVF];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_q <= 1'b0;
            msg_q    <= 1'b0;
            mask_q   <= '0;
            bridge_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            legacy_q <= (legacy_q && !clr_legacy) || nonempty_next;
            msg_q    <= (msg_q && !clr_msg) || msi_pulse;
            ovf_q    <= (ovf_q && !clr_ovf) || overflow_evt;
            if (wr_mask)
                mask_q <= wdata;
            if (wr_stat)
                bridge_q <= wdata[B_BRIDGE];
        end
    end

    always_comb begin
        irq = (legacy_q && mask_q[B_LEGACY]) || (msg_q && mask_q[B_MSG]);
    end

    AST_LEGACY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        q_nonempty |-> legacy_q); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_stat && wdata[B_OVF])) |=> ovf_q); // R5
    AST_MSG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |=> msg_q); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[B_MSG] == 1'b0 && mask_q[B_LEGACY] == 1'b0) |-> !irq); // R9
endmodule

// File: rtl/rp_intq_ctrl.sv
module rp_intq_ctrl
    import rp_intq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 12,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic [1:0]    evt_lane,
    input  logic          evt_level,
    input  logic          msi_pulse,
    input  logic          link_up,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic          wr_any, wr_pend, wr_mask, wr_stat, pop_req;
    logic          q_nonempty, nonempty_next, overflow_evt;
    logic          legacy_q, msg_q, bridge_q, ovf_q;
    logic [DW-1:0] mask_q;
    intx_rec_t     push_rec, head_rec;

    always_comb begin
        wr_any         = bus_sel && bus_we;
        wr_pend        = wr_any && (bus_addr == AW'(OFF_PEND));
        wr_mask        = wr_any && (bus_addr == AW'(OFF_MASK));
        wr_stat        = wr_any && (bus_addr == AW'(OFF_STAT));
        pop_req        = wr_any && ((bus_addr == AW'(OFF_HEAD1)) || (bus_addr == AW'(OFF_HEAD2)));
        push_rec.lane  = evt_lane;
        push_rec.level = evt_level;
    end

    rp_intq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_req      (evt_valid),
        .push_rec      (push_rec),
        .pop_req       (pop_req),
        .head_rec      (head_rec),
        .q_nonempty    (q_nonempty),
        .nonempty_next (nonempty_next),
        .overflow_evt  (overflow_evt)
    );

    rp_intq_regs #(.DW(DW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_pend       (wr_pend),
        .wr_mask       (wr_mask),
        .wr_stat       (wr_stat),
        .wdata         (bus_wdata),
        .msi_pulse     (msi_pulse),
        .q_nonempty    (q_nonempty),
        .nonempty_next (nonempty_next),
        .overflow_evt  (overflow_evt),
        .legacy_q      (legacy_q),
        .msg_q         (msg_q),
        .mask_q        (mask_q),
        .bridge_q      (bridge_q),
        .ovf_q         (ovf_q),
        .irq           (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_PEND)) begin
            bus_rdata[B_LEGACY] = legacy_q;
            bus_rdata[B_MSG]    = msg_q;
        end else if (bus_addr == AW'(OFF_MASK)) begin
            bus_rdata = mask_q;
        end else if (bus_addr == AW'(OFF_LINK)) begin
            bus_rdata[B_LINK] = link_up;
        end else if (bus_addr == AW'(OFF_STAT)) begin
            bus_rdata[B_BRIDGE] = bridge_q;
            bus_rdata[B_NEMPTY] = q_nonempty;
            bus_rdata[B_OVF]    = ovf_q;
        end else if (bus_addr == AW'(OFF_HEAD1)) begin
            if (q_nonempty) begin
                bus_rdata[B_VALID]         = 1'b1;
                bus_rdata[B_LEVEL]         = head_rec.level;
                bus_rdata[B_LANE+1:B_LANE] = head_rec.lane;
            end
        end
    end

    AST_HEAD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_nonempty && bus_addr == AW'(OFF_HEAD1)) |-> (bus_rdata == '0)); // R4
endmodule

// File: tb/rp_intq_ctrl_bench.sv
module rp_intq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_lane = 2'd0;
    logic        evt_level = 1'b0;
    logic        msi_pulse = 1'b0;
    logic        link_up = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] expq [64];
    int qh = 0;
    int qt = 0;

    always #4 clk = ~clk;

    rp_intq_ctrl u_rp_intq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_lane(evt_lane),
        .evt_level(evt_level), .msi_pulse(msi_pulse), .link_up(link_up),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] enc(input int lane, input int lvl);
        return 32'h8000_0000 | (32'(lvl & 1) << 29) | (32'(lane & 3) << 27);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push(input int lane, input int lvl, input bit track);
        @(negedge clk);
        evt_valid = 1'b1; evt_lane = 2'(lane); evt_level = 1'(lvl);
        @(negedge clk);
        evt_valid = 1'b0;
        if (track) begin expq[qt] = enc(lane, lvl); qt++; end
    endtask

    task automatic check_irq(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h138, v); chk("R1 pending", v, 0);
        rd(12'h13C, v); chk("R1 mask", v, 0);
        rd(12'h148, v); chk("R1 status", v, 0);
        rd(12'h158, v); chk("R1 head1", v, 0);
        rd(12'h15C, v); chk("R1 head2", v, 0);
        check_irq("R1 irq", 1'b0);
    endtask

    task automatic t_link();
        logic [31:0] v;
        link_up = 1'b1; rd(12'h144, v); chk("R11 link up", v, 32'h0000_0800);
        link_up = 1'b0; rd(12'h144, v); chk("R11 link down", v, 0);
    endtask

    task automatic t_empty_pop();
        logic [31:0] v;
        wr(12'h158, 32'h0);
        wr(12'h15C, 32'hFFFF_FFFF);
        push(2, 1, 1'b0);
        rd(12'h158, v); chk("R4 head after empty pops", v, enc(2, 1));
        chk("R2 encoding lane2 assert", v, 32'hB000_0000);
        rd(12'h15C, v); chk("R2 head2 zero", v, 0);
        wr(12'h15C, 32'h0);
        rd(12'h158, v); chk("R4 empty head1", v, 0);
        wr(12'h138, 32'h0001_0000);
    endtask

    task automatic t_order();
        logic [31:0] v;
        push(1, 0, 1'b0); push(3, 1, 1'b0); push(0, 0, 1'b0);
        wr(12'h138, 32'h0001_0000);
        rd(12'h138, v); chk("R7 legacy held while queued", v, 32'h0001_0000);
        rd(12'h158, v); chk("R3 first", v, enc(1, 0));
        wr(12'h158, 32'h0);
        rd(12'h158, v); chk("R3 second", v, enc(3, 1));
        wr(12'h15C, 32'h0);
        rd(12'h158, v); chk("R3 third", v, enc(0, 0));
        chk("R2 encoding lane0 release", v, 32'h8000_0000);
        wr(12'h158, 32'h0);
        rd(12'h158, v); chk("R3 drained", v, 0);
        rd(12'h138, v); chk("R7 pending stays until cleared", v, 32'h0001_0000);
        wr(12'h138, 32'h0001_0000);
        rd(12'h138, v); chk("R7 cleared when empty", v, 0);
    endtask

    task automatic t_bridge();
        logic [31:0] v;
        wr(12'h148, 32'hFFFF_FFFF);
        rd(12'h148, v); chk("R10 bridge set, not-empty ignores write", v, 32'h0000_0001);
        push(1, 1, 1'b0);
        rd(12'h148, v); chk("R10 not-empty", v, 32'h0004_0001);
        wr(12'h148, 32'h0);
        rd(12'h148, v); chk("R10 bridge cleared", v, 32'h0004_0000);
        wr(12'h158, 32'h0);
        wr(12'h138, 32'h0001_0000);
        rd(12'h148, v); chk("R10 empty again", v, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        qh = 0; qt = 0;
        for (int i = 0; i < 15; i++) push(i % 4, (i / 4) % 2, 1'b1);
        rd(12'h148, v); chk("R5 fifteen held, no overflow", v, 32'h0004_0000);
        push(3, 1, 1'b0);
        rd(12'h148, v); chk("R5 overflow set", v, 32'h000C_0000);
        wr(12'h148, 32'h0);
        rd(12'h148, v); chk("R5 overflow sticky", v, 32'h000C_0000);
        wr(12'h148, 32'h0008_0000);
        rd(12'h148, v); chk("R5 overflow cleared", v, 32'h0004_0000);
        @(negedge clk);
        evt_valid = 1'b1; evt_lane = 2'd2; evt_level = 1'b0;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h158; bus_wdata = 0;
        @(negedge clk);
        evt_valid = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        qh++; expq[qt] = enc(2, 0); qt++;
        rd(12'h148, v); chk("R6 no overflow on swap", v, 32'h0004_0000);
        for (int i = 0; i < 15; i++) begin
            rd(12'h158, v); chk("R6 drain order", v, expq[qh]); qh++;
            wr(12'h158, 32'h0);
        end
        rd(12'h158, v); chk("R5 exactly fifteen held", v, 0);
        wr(12'h138, 32'h0001_0000);
    endtask

    task automatic t_msi_irq();
        logic [31:0] v;
        @(negedge clk); msi_pulse = 1'b1;
        @(negedge clk); msi_pulse = 1'b0;
        rd(12'h138, v); chk("R8 message cause set", v, 32'h0002_0000);
        check_irq("R9 masked off", 1'b0);
        wr(12'h13C, 32'h0002_0000);
        rd(12'h13C, v); chk("R9 mask readback", v, 32'h0002_0000);
        check_irq("R9 message unmasked", 1'b1);
        wr(12'h138, 32'h0000_0000);
        rd(12'h138, v); chk("R8 zero write keeps cause", v, 32'h0002_0000);
        wr(12'h138, 32'h0002_0000);
        rd(12'h138, v); chk("R8 cause cleared", v, 0);
        check_irq("R9 irq low after clear", 1'b0);
        wr(12'h13C, 32'h0001_0000);
        push(0, 1, 1'b0);
        check_irq("R9 legacy unmasked", 1'b1);
        wr(12'h158, 32'h0);
        check_irq("R9 legacy pending after pop", 1'b1);
        wr(12'h138, 32'h0001_0000);
        check_irq("R9 irq low after legacy clear", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_link();
        t_empty_pop();
        t_order();
        t_bridge();
        t_overflow();
        t_msi_irq();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule